// File: doc/BRIEF.md
# Word-Valid Copyback Line Cache

This block is a direct-mapped cache that sits in front of one segment of embedded DRAM and serves instruction fetches and data accesses alike. Each line is 256 bits, made of eight 32-bit words. Every word carries its own valid flag, so a line can be partly present. A core access touches one, two or four words and completes in the cycle it is presented when it hits. There are no wait states on a hit.

Writes that hit update the line in place and mark it dirty. Writes that miss do not claim a line. They leave through the copyback port as a word-masked write. Line fills arrive on a separate port from the prefetch path, and the cache stores them as they are delivered. A fill that replaces a dirty line first pushes that line out through the copyback port. A disable input routes every access around the arrays and keeps their contents intact.

Top module: `wordval_cache`

## Requirements
- R1: After reset every line is empty. No core read hits, and `cb_valid` stays low until a copyback event occurs.
- R2: A read hits when the line at the indexed slot holds the same tag and every word the access touches is valid. On a hit, `rsp_hit` is high in the same cycle. The touched words appear on `rsp_rdata` in ascending order from bits [31:0] upward, and unused lanes are zero. `rsp_rdata` is all zero whenever no read hit is reported.
- R3: A read that touches any invalid word, or that addresses a slot whose tag differs, is a miss. It changes no cache state.
- R4: `req_size` selects the word count: 0 gives one word, 1 gives two words, and 2 or 3 give four words. The word offset (`req_addr` bits [2:0]) is rounded down to a multiple of that count.
- R5: A write whose tag matches a slot holding at least one valid word is a hit. It stores the touched words, marks them valid and marks the line dirty, and it emits no copyback.
- R6: A write that is not a hit leaves the cache unchanged. One cycle later, `cb_valid` pulses with `cb_addr` set to the line address and `cb_mask` set to the touched words. The write data appears in those word positions of `cb_data`, and all other positions are zero.
- R7: A fill whose tag matches a non-empty slot writes only the masked words that are not already valid and keeps the others. A fill to an empty slot, or with a different tag, replaces the line. The replaced line takes the new tag, its valid flags equal `fill_mask`, and it is clean.
- R8: A replacing fill over a dirty line pushes the old line one cycle later. The push carries the old line address, the old valid flags as `cb_mask`, and the valid words. Replacing a clean line emits nothing.
- R9: While `fill_valid` is high, `req_grant` is low. In that cycle the core request is ignored: it has no hit, no state change and no copyback.
- R10: While `cache_off` is high, reads miss, writes leave as in R6, and fills are dropped. Contents stored earlier are still present once the cache is enabled again.
- R11: `cb_valid` is high for exactly one cycle per copyback event and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_off | input | 1 | Bypass: arrays neither hit nor load |
| req_valid | input | 1 | Core access present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Word count code (see R4) |
| req_addr | input | ADDR_W | Word address: offset [2:0], slot next, tag on top |
| req_wdata | input | 128 | Write words, first word in bits [31:0] |
| req_grant | output | 1 | Core access accepted this cycle |
| rsp_hit | output | 1 | Access hit (read or write) |
| rsp_rdata | output | 128 | Read words of a hit |
| fill_valid | input | 1 | Fill present from prefetch path |
| fill_addr | input | ADDR_W-3 | Line address of the fill |
| fill_mask | input | 8 | Words carried by the fill |
| fill_data | input | 256 | Fill line, word w in bits [32w+31:32w] |
| cb_valid | output | 1 | Copyback push strobe |
| cb_addr | output | ADDR_W-3 | Line address of the push |
| cb_mask | output | 8 | Words carried by the push |
| cb_data | output | 256 | Pushed words, zero outside the mask |

## Verification
The bench targets partly valid lines. A read that straddles a valid and an invalid word must miss. A design that checked only the tag would return stale words. It also tests merging fills, where a design that overwrote valid words would lose earlier write hits. A size-3 access and unaligned offsets probe the rounding rule, because an unrounded lane shift would scramble `rsp_rdata`. Eviction is tested on dirty, clean and disabled lines. The cycle where a fill and a write arrive together is tested as well: a design that let the write through would corrupt the line or emit a spurious push.

// File: rtl/wvc_pkg.sv
`timescale 1ns/1ps
package wvc_pkg;

  localparam int WORD_W    = 32;
  localparam int BUS_WORDS = 4;
  localparam int BUS_W     = WORD_W * BUS_WORDS;

  // number of 32-bit words touched by a size code
  function automatic int span_words(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // first touched word: offset rounded down to the access span
  function automatic int first_word(input logic [1:0] sz, input int off);
    return off - (off % span_words(sz));
  endfunction

endpackage

// File: rtl/wvc_store.sv
`timescale 1ns/1ps
module wvc_store #(
  parameter  int LINES  = 8,
  parameter  int WPL    = 8,
  parameter  int TAG_W  = 10,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LINE_W = WPL * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup port for core requests
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [WPL-1:0]    ra_vld,
  output logic [LINE_W-1:0] ra_data,
  // lookup port for fills
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [WPL-1:0]    rb_vld,
  output logic              rb_dirty,
  output logic [LINE_W-1:0] rb_data,
  // core write-hit update
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WPL-1:0]    wr_mask,
  input  logic [LINE_W-1:0] wr_line,
  // fill update
  input  logic              fl_en,
  input  logic              fl_replace,
  input  logic [IDX_W-1:0]  fl_idx,
  input  logic [TAG_W-1:0]  fl_tag,
  input  logic [WPL-1:0]    fl_mask,
  input  logic [LINE_W-1:0] fl_line
);

  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [WPL-1:0]    vld_q   [LINES];
  logic              dirty_q [LINES];
  logic [LINE_W-1:0] data_q  [LINES];

  assign ra_tag   = tag_q[ra_idx];
  assign ra_vld   = vld_q[ra_idx];
  assign ra_data  = data_q[ra_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_vld   = vld_q[rb_idx];
  assign rb_dirty = dirty_q[rb_idx];
  assign rb_data  = data_q[rb_idx];

  // state flags: reset to empty and clean
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        vld_q[i]   <= '0;
        dirty_q[i] <= 1'b0;
      end
    end else begin
      if (wr_en) begin
        vld_q[wr_idx]   <= vld_q[wr_idx] | wr_mask;
        dirty_q[wr_idx] <= 1'b1;
      end
      if (fl_en) begin
        if (fl_replace) begin
          vld_q[fl_idx]   <= fl_mask;
          dirty_q[fl_idx] <= 1'b0;
        end else begin
          vld_q[fl_idx] <= vld_q[fl_idx] | fl_mask;
        end
      end
    end
  end

  // tags and words carry no reset; valid flags qualify them
  always_ff @(posedge clk) begin
    if (fl_en && fl_replace) tag_q[fl_idx] <= fl_tag;
    for (int w = 0; w < WPL; w++) begin
      if (wr_en && wr_mask[w])
        data_q[wr_idx][w*32 +: 32] <= wr_line[w*32 +: 32];
      if (fl_en && fl_mask[w] && (fl_replace || !vld_q[fl_idx][w]))
        data_q[fl_idx][w*32 +: 32] <= fl_line[w*32 +: 32];
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && fl_en)); // R9

  AST_DIRTY_HAS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    rb_dirty |-> (|rb_vld)); // R8

endmodule

// File: rtl/wvc_lookup.sv
`timescale 1ns/1ps
module wvc_lookup
  import wvc_pkg::*;
#(
  parameter  int WPL    = 8,
  parameter  int TAG_W  = 10,
  localparam int OFF_W  = $clog2(WPL),
  localparam int LINE_W = WPL * 32
) (
  input  logic              active,
  input  logic              is_write,
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [WPL-1:0]    line_vld,
  input  logic [LINE_W-1:0] line_data,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [WPL-1:0]    touched,
  output logic [BUS_W-1:0]  rd_words,
  output logic [LINE_W-1:0] line_wdata
);

  int   first_w;
  int   span_n;
  logic present;
  logic all_valid;
  logic [BUS_W-1:0] gathered;

  always_comb begin
    span_n  = span_words(size);
    first_w = first_word(size, int'(off));
    for (int w = 0; w < WPL; w++)
      touched[w] = (w >= first_w) && (w < first_w + span_n);
  end

  // gather touched line words into bus lanes, scatter bus lanes into line words
  always_comb begin
    gathered   = '0;
    line_wdata = '0;
    for (int k = 0; k < BUS_WORDS; k++) begin
      for (int w = 0; w < WPL; w++) begin
        if (k < span_n && w == first_w + k) begin
          gathered[k*32 +: 32]   = line_data[w*32 +: 32];
          line_wdata[w*32 +: 32] = bus_wdata[k*32 +: 32];
        end
      end
    end
  end

  assign present   = (line_tag == req_tag) && (|line_vld);
  assign all_valid = ((touched & ~line_vld) == '0);
  assign rd_hit    = active && !is_write && present && all_valid;
  assign wr_hit    = active && is_write && present;
  assign rd_words  = rd_hit ? gathered : '0;

endmodule

// File: rtl/wvc_cbport.sv
`timescale 1ns/1ps
module wvc_cbport #(
  parameter  int WPL    = 8,
  parameter  int LA_W   = 13,
  localparam int LINE_W = WPL * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [LA_W-1:0]   push_addr,
  input  logic [WPL-1:0]    push_mask,
  input  logic [LINE_W-1:0] push_line,
  output logic              cb_valid,
  output logic [LA_W-1:0]   cb_addr,
  output logic [WPL-1:0]    cb_mask,
  output logic [LINE_W-1:0] cb_data
);

  logic [LINE_W-1:0] masked_line;

  always_comb begin
    for (int w = 0; w < WPL; w++)
      masked_line[w*32 +: 32] = push_mask[w] ? push_line[w*32 +: 32] : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_valid <= 1'b0;
      cb_addr  <= '0;
      cb_mask  <= '0;
      cb_data  <= '0;
    end else begin
      cb_valid <= push;
      cb_addr  <= push ? push_addr : '0;
      cb_mask  <= push ? push_mask : '0;
      cb_data  <= push ? masked_line : '0;
    end
  end

  AST_PUSH_HAS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid |-> (|cb_mask)); // R11

endmodule

// File: rtl/wordval_cache.sv
`timescale 1ns/1ps
module wordval_cache
  import wvc_pkg::*;
#(
  parameter  int LINES  = 8,
  parameter  int WPL    = 8,
  parameter  int ADDR_W = 16,
  localparam int OFF_W  = $clog2(WPL),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LA_W   = ADDR_W - OFF_W,
  localparam int LINE_W = WPL * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_off,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_grant,
  output logic              rsp_hit,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic              fill_valid,
  input  logic [LA_W-1:0]   fill_addr,
  input  logic [WPL-1:0]    fill_mask,
  input  logic [LINE_W-1:0] fill_data,
  output logic              cb_valid,
  output logic [LA_W-1:0]   cb_addr,
  output logic [WPL-1:0]    cb_mask,
  output logic [LINE_W-1:0] cb_data
);

  // address split
  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;

  assign req_off  = req_addr[OFF_W-1:0];
  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign fill_idx = fill_addr[IDX_W-1:0];
  assign fill_tag = fill_addr[LA_W-1 -: TAG_W];

  // named events
  logic req_fire;
  logic lk_active;
  logic lk_rd_hit;
  logic lk_wr_hit;
  logic wr_miss;
  logic fl_act;
  logic fl_same;
  logic fl_replace;
  logic evict;
  logic push;

  logic [TAG_W-1:0]  ra_tag,  rb_tag;
  logic [WPL-1:0]    ra_vld,  rb_vld;
  logic [LINE_W-1:0] ra_data, rb_data;
  logic              rb_dirty;
  logic [WPL-1:0]    lk_touched;
  logic [LINE_W-1:0] lk_line_wdata;
  logic [LA_W-1:0]   push_addr;
  logic [WPL-1:0]    push_mask;
  logic [LINE_W-1:0] push_line;

  assign req_grant = !fill_valid;
  assign req_fire  = req_valid && !fill_valid;
  assign lk_active = req_fire && !cache_off;
  assign rsp_hit   = lk_rd_hit || lk_wr_hit;
  assign wr_miss   = req_fire && req_write && !lk_wr_hit;

  assign fl_act     = fill_valid && !cache_off;
  assign fl_same    = (rb_tag == fill_tag) && (|rb_vld);
  assign fl_replace = !fl_same;
  assign evict      = fl_act && fl_replace && rb_dirty;
  assign push       = evict || wr_miss;

  always_comb begin
    if (evict) begin
      push_addr = {rb_tag, fill_idx};
      push_mask = rb_vld;
      push_line = rb_data;
    end else begin
      push_addr = req_addr[ADDR_W-1:OFF_W];
      push_mask = lk_touched;
      push_line = lk_line_wdata;
    end
  end

  wvc_store #(
    .LINES (LINES),
    .WPL   (WPL),
    .TAG_W (TAG_W)
  ) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ra_idx     (req_idx),
    .ra_tag     (ra_tag),
    .ra_vld     (ra_vld),
    .ra_data    (ra_data),
    .rb_idx     (fill_idx),
    .rb_tag     (rb_tag),
    .rb_vld     (rb_vld),
    .rb_dirty   (rb_dirty),
    .rb_data    (rb_data),
    .wr_en      (lk_wr_hit),
    .wr_idx     (req_idx),
    .wr_mask    (lk_touched),
    .wr_line    (lk_line_wdata),
    .fl_en      (fl_act),
    .fl_replace (fl_replace),
    .fl_idx     (fill_idx),
    .fl_tag     (fill_tag),
    .fl_mask    (fill_mask),
    .fl_line    (fill_data)
  );

  wvc_lookup #(
    .WPL   (WPL),
    .TAG_W (TAG_W)
  ) lookup_i (
    .active     (lk_active),
    .is_write   (req_write),
    .size       (req_size),
    .off        (req_off),
    .req_tag    (req_tag),
    .bus_wdata  (req_wdata),
    .line_tag   (ra_tag),
    .line_vld   (ra_vld),
    .line_data  (ra_data),
    .rd_hit     (lk_rd_hit),
    .wr_hit     (lk_wr_hit),
    .touched    (lk_touched),
    .rd_words   (rsp_rdata),
    .line_wdata (lk_line_wdata)
  );

  wvc_cbport #(
    .WPL  (WPL),
    .LA_W (LA_W)
  ) cbport_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (push_addr),
    .push_mask (push_mask),
    .push_line (push_line),
    .cb_valid  (cb_valid),
    .cb_addr   (cb_addr),
    .cb_mask   (cb_mask),
    .cb_data   (cb_data)
  );

  AST_WHIT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_write && rsp_hit) |=> !cb_valid); // R5

  AST_WMISS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_write && !rsp_hit) |=> (cb_valid && cb_mask == $past(lk_touched))); // R6

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    cache_off |-> !rsp_hit); // R10

  AST_FILL_BLOCKS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (!req_grant && !rsp_hit)); // R9

  AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_rdata == '0)); // R2

endmodule

// File: tb/wordval_cache_tb_top.sv
`timescale 1ns/1ps
module wordval_cache_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cache_off;
  logic         req_valid;
  logic         req_write;
  logic [1:0]   req_size;
  logic [15:0]  req_addr;
  logic [127:0] req_wdata;
  logic         req_grant;
  logic         rsp_hit;
  logic [127:0] rsp_rdata;
  logic         fill_valid;
  logic [12:0]  fill_addr;
  logic [7:0]   fill_mask;
  logic [255:0] fill_data;
  logic         cb_valid;
  logic [12:0]  cb_addr;
  logic [7:0]   cb_mask;
  logic [255:0] cb_data;

  always #2 clk = ~clk; // 250 MHz

  wordval_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cache_off(cache_off),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
    .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_mask(fill_mask),
    .fill_data(fill_data),
    .cb_valid(cb_valid), .cb_addr(cb_addr), .cb_mask(cb_mask), .cb_data(cb_data)
  );

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;
  bit off_mode = 0;

  // behavioural reference: per-slot tag, word flags, dirty flag, words
  int        m_tag [8];
  bit [7:0]  m_vld [8];
  bit        m_dty [8];
  bit [31:0] m_dat [8][8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int A(input int tg, input int ix, input int o);
    return tg * 64 + ix * 8 + o;
  endfunction

  function automatic int L(input int tg, input int ix);
    return tg * 8 + ix;
  endfunction

  function automatic logic [255:0] pat(input int seed);
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = 32'hA000_0000 + seed * 32'h100 + w;
    return v;
  endfunction

  task automatic cyc(input bit rv, input bit rw, input bit [1:0] sz, input int addr,
                     input logic [127:0] wd, input bit fv, input int faddr,
                     input bit [7:0] fm, input logic [255:0] fd, input string tag);
    bit fire, act, present, allv, erh, ewh, nv, same;
    int o, ix, tg, n, f, fi, ft, naddr;
    bit [7:0] nmask;
    logic [127:0] exp_rd;
    logic [255:0] ndata;
    req_valid = rv; req_write = rw; req_size = sz; req_addr = addr[15:0]; req_wdata = wd;
    fill_valid = fv; fill_addr = faddr[12:0]; fill_mask = fm; fill_data = fd;
    cache_off = off_mode;
    #1;
    fire = rv && !fv;
    act  = fire && !off_mode;
    o = addr % 8; ix = (addr / 8) % 8; tg = addr / 64;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    f = o - (o % n);
    present = (m_vld[ix] != 0) && (m_tag[ix] == tg);
    allv = 1;
    for (int j = f; j < f + n; j++) if (!m_vld[ix][j]) allv = 0;
    erh = act && !rw && present && allv;
    ewh = act && rw && present;
    exp_rd = '0;
    if (erh) for (int k = 0; k < n; k++) exp_rd[k*32 +: 32] = m_dat[ix][f+k];
    chk(req_grant == !fv, tag, "req_grant", 256'(req_grant), 256'(!fv));
    chk(rsp_hit == (erh || ewh), tag, "rsp_hit", 256'(rsp_hit), 256'(erh || ewh));
    chk(rsp_rdata == exp_rd, tag, "rsp_rdata", 256'(rsp_rdata), 256'(exp_rd));
    // next state of the reference
    nv = 0; naddr = 0; nmask = 0; ndata = '0;
    if (ewh) begin
      for (int k = 0; k < n; k++) begin
        m_dat[ix][f+k] = wd[k*32 +: 32];
        m_vld[ix][f+k] = 1'b1;
      end
      m_dty[ix] = 1'b1;
    end else if (fire && rw) begin
      nv = 1; naddr = addr / 8;
      for (int k = 0; k < n; k++) begin
        nmask[f+k] = 1'b1;
        ndata[(f+k)*32 +: 32] = wd[k*32 +: 32];
      end
    end
    if (fv && !off_mode) begin
      fi = faddr % 8; ft = faddr / 8;
      same = (m_vld[fi] != 0) && (m_tag[fi] == ft);
      if (same) begin
        for (int w = 0; w < 8; w++)
          if (fm[w] && !m_vld[fi][w]) begin
            m_dat[fi][w] = fd[w*32 +: 32];
            m_vld[fi][w] = 1'b1;
          end
      end else begin
        if (m_dty[fi]) begin
          nv = 1; naddr = m_tag[fi] * 8 + fi; nmask = m_vld[fi];
          for (int w = 0; w < 8; w++) if (m_vld[fi][w]) ndata[w*32 +: 32] = m_dat[fi][w];
        end
        m_tag[fi] = ft; m_vld[fi] = fm; m_dty[fi] = 1'b0;
        for (int w = 0; w < 8; w++) if (fm[w]) m_dat[fi][w] = fd[w*32 +: 32];
      end
    end
    @(posedge clk);
    #1;
    chk(cb_valid == nv, nv ? tag : "R11", "cb_valid", 256'(cb_valid), 256'(nv));
    if (nv) begin
      chk(cb_addr == naddr[12:0], tag, "cb_addr", 256'(cb_addr), 256'(naddr[12:0]));
      chk(cb_mask == nmask, tag, "cb_mask", 256'(cb_mask), 256'(nmask));
      chk(cb_data == ndata, tag, "cb_data", cb_data, ndata);
    end
  endtask

  task automatic rd(input bit [1:0] sz, input int addr, input string tag);
    cyc(1, 0, sz, addr, '0, 0, 0, 0, '0, tag);
  endtask
  task automatic wr(input bit [1:0] sz, input int addr, input logic [127:0] wd, input string tag);
    cyc(1, 1, sz, addr, wd, 0, 0, 0, '0, tag);
  endtask
  task automatic fill(input int la, input bit [7:0] fm, input logic [255:0] fd, input string tag);
    cyc(0, 0, 0, 0, '0, 1, la, fm, fd, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, '0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_tag[i] = 0; m_vld[i] = 0; m_dty[i] = 0; end
    rst_n = 1'b0; cache_off = 0; req_valid = 0; req_write = 0; req_size = 0;
    req_addr = 0; req_wdata = 0; fill_valid = 0; fill_addr = 0; fill_mask = 0; fill_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: empty after reset
    chk(cb_valid == 1'b0, "R1", "cb_valid after reset", 256'(cb_valid), 256'd0);
    for (int ix = 0; ix < 8; ix++) rd(2, A(0, ix, 0), "R1");
    idle("R11");
    // partial line, read hits and misses
    fill(L(5, 1), 8'h0F, pat(1), "R7");
    rd(2, A(5, 1, 0), "R2");
    rd(0, A(5, 1, 5), "R3");
    rd(1, A(5, 1, 2), "R2");
    rd(2, A(5, 1, 4), "R3");
    rd(1, A(5, 1, 3), "R3");
    rd(3, A(5, 1, 3), "R4");
    rd(2, A(5, 1, 2), "R4");
    rd(1, A(5, 1, 1), "R4");
    rd(0, A(5, 1, 2), "R2");
    rd(0, A(6, 1, 0), "R3");
    // write hit, including into an invalid word of a present line
    wr(0, A(5, 1, 6), 128'h0000_CAFE, "R5");
    rd(0, A(5, 1, 6), "R5");
    wr(2, A(5, 1, 1), {32'h44, 32'h33, 32'h22, 32'h11}, "R5");
    rd(2, A(5, 1, 0), "R5");
    // write miss: no allocation
    wr(1, A(9, 1, 2), {96'h0, 32'hBEEF}, "R6");
    rd(1, A(9, 1, 2), "R6");
    wr(2, A(0, 4, 0), {32'hD, 32'hC, 32'hB, 32'hA}, "R6");
    wr(0, A(0, 4, 7), 128'h77, "R6");
    rd(0, A(0, 4, 7), "R6");
    // merging fill keeps existing words
    fill(L(5, 1), 8'hFF, pat(2), "R7");
    rd(2, A(5, 1, 4), "R7");
    rd(2, A(5, 1, 0), "R7");
    // replacing fills
    fill(L(7, 1), 8'h33, pat(3), "R8");
    rd(2, A(5, 1, 0), "R8");
    rd(1, A(7, 1, 4), "R8");
    rd(1, A(7, 1, 2), "R7");
    fill(L(3, 1), 8'hFF, pat(4), "R8");
    // fill and core in the same cycle
    cyc(1, 1, 2, A(3, 1, 0), 128'h1234, 1, L(2, 6), 8'h0F, pat(5), "R9");
    cyc(1, 0, 2, A(3, 1, 0), '0, 1, L(2, 6), 8'hF0, pat(6), "R9");
    rd(2, A(3, 1, 0), "R9");
    rd(2, A(2, 6, 4), "R9");
    // disabled cache
    off_mode = 1;
    rd(2, A(3, 1, 0), "R10");
    wr(0, A(3, 1, 2), 128'h5555, "R10");
    fill(L(1, 2), 8'hFF, pat(7), "R10");
    off_mode = 0;
    rd(2, A(3, 1, 0), "R10");
    rd(0, A(1, 2, 0), "R10");
    // sweep: every slot, every size and offset
    for (int ix = 0; ix < 8; ix++) begin
      fill(L(10 + ix, ix), 8'h80 | (8'h1 << ix), pat(20 + ix), "R7");
      wr(0, A(10 + ix, ix, (ix + 3) % 8), 128'(32'hF00 + ix), "R5");
      fill(L(10 + ix, ix), 8'h0F, pat(40 + ix), "R7");
      for (int s = 0; s < 3; s++)
        for (int o = 0; o < 8; o++)
          rd(2'(s), A(10 + ix, ix, o), "R2");
    end
    for (int ix = 0; ix < 8; ix++) begin
      fill(L(30 + ix, ix), 8'hFF, pat(60 + ix), "R8");
      rd(2, A(30 + ix, ix, 4), "R8");
    end
    idle("R11");
    idle("R11");
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule